// File: doc/BRIEF.md
# Bus Acknowledge Delay Generator

This block sits on a 68000-style asynchronous bus beside a slow 16-bit memory. The memory occupies a fixed address window. The block watches the top address bits while the address strobe is low. When a cycle falls inside the window, the block starts a chain of flip-flops clocked by the CPU clock. A low level moves one stage down the chain on each clock edge. A tap-select input chooses which stage drives the data-transfer acknowledge, so the bus master waits a whole number of clock periods before it finishes the cycle. That number must cover the memory's access time. For example, a 450 ns part on a bus clock of about 130 ns needs at least 4 periods.

The acknowledge is an open-drain style output. It either pulls the shared line low or leaves it in high impedance, so other devices can wire-OR onto the same line and an external pull-up holds it high. The drive enable is also brought out as a plain signal. The block also produces registered, active-low chip-select, read-strobe and write-strobe outputs for the memory. When the address strobe returns high, every stage resets and the acknowledge is released, so the next cycle starts again from stage zero.

Top module: `bus_ack_delay`

## Requirements
- R1: The block responds only when `addr_top` (byte address bits 23..21) equals 3'b100, that is the window 0x800000 to 0x9FFFFF. For any other value `ack_pull` stays 0 and all three memory strobes stay high.
- R2: In an in-window read cycle (`rw` = 1, `as_n` = 0), `ack_pull` goes to 1 after clock edge number `tap_sel`+1, counted from the first edge that samples the selected cycle, and not earlier.
- R3: An in-window write cycle (`rw` = 0) is acknowledged with the same delay as a read.
- R4: The tap encoding is a delay of `tap_sel`+1 clock periods: 0 gives 1 period and 7 gives 8 periods.
- R5: On the first clock edge that samples `as_n` = 1, the chain clears, `ack_pull` goes to 0 and the strobes go high. The next cycle then waits its full delay again, even when the previous cycle ended before its acknowledge appeared.
- R6: `ack_n` is driven to 0 exactly when `ack_pull` is 1, and is high-impedance otherwise. It is never driven to 1.
- R7: `mem_cs_n` goes low on the first edge that samples an in-window cycle. At the same edge `mem_rd_n` goes low if `rw` = 1, or `mem_wr_n` goes low if `rw` = 0. The read and write strobes are never low together.
- R8: While the synchronous reset `rst` is high, the edge clears the chain, releases the acknowledge and forces all strobes high, even when an in-window cycle is present.
- R9: Once asserted, `ack_pull` stays at 1 without a gap for as long as the in-window cycle continues and `tap_sel` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; the chain advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_top | input | 3 | Byte address bits 23..21 |
| tap_sel | input | 3 | Delay select, delay = value+1 periods |
| ack_n | output | 1 | Open-drain acknowledge: 0 or high-impedance |
| ack_pull | output | 1 | 1 while the acknowledge line is pulled low |
| mem_cs_n | output | 1 | Memory chip select, active low, registered |
| mem_rd_n | output | 1 | Memory read strobe, active low, registered |
| mem_wr_n | output | 1 | Memory write strobe, active low, registered |

## Verification
Some rules are checked on every cycle. An out-of-window cycle or a high address strobe leaves the acknowledge released on the next edge. Reset releases everything. The read and write strobes never overlap, and a read or write strobe never appears without chip select. An asserted acknowledge does not drop while its cycle and tap are held. Other behaviour can only be shown by the bench's scenarios: the exact edge on which the acknowledge first appears for each tap value, the equal delay for writes, the full restart after a cycle that was cut short, and the open-drain line levels with a pull-up attached.

// File: rtl/ackdly_pkg.sv
package ackdly_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/ackdly_window.sv
module ackdly_window
  import ackdly_pkg::*;
#(
  parameter int              WIN_BITS   = 3,
  parameter logic [WIN_BITS-1:0] WIN_MATCH = 3'b100,
  parameter bit              ACK_WRITES = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                as_n,
  input  logic                rw,
  input  logic [WIN_BITS-1:0] addr_top,
  output logic                run,
  output logic                cs_n,
  output logic                rd_n,
  output logic                wr_n
);
  logic      hit;
  logic      kind_ok;
  acc_kind_t kind;

  assign hit = (addr_top == WIN_MATCH) && !as_n;

  always_comb begin
    if (!hit)    kind = ACC_IDLE;
    else if (rw) kind = ACC_READ;
    else         kind = ACC_WRITE;
  end

  generate
    if (ACK_WRITES) begin : g_all
      assign kind_ok = (kind != ACC_IDLE);
    end else begin : g_rd_only
      assign kind_ok = (kind == ACC_READ);
    end
  endgenerate

  assign run = kind_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= 1'b1;
      rd_n <= 1'b1;
      wr_n <= 1'b1;
    end else begin
      cs_n <= (kind == ACC_IDLE);
      rd_n <= (kind != ACC_READ);
      wr_n <= (kind != ACC_WRITE);
    end
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R7
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !cs_n);
  // R1
  outside_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_top != WIN_MATCH) |=> cs_n);
endmodule

// File: rtl/ackdly_chain.sv
module ackdly_chain #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [DEPTH-1:0] stage_n
);
  logic clear;
  assign clear = rst || !run;

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (clear) stage_n[0] <= 1'b1;
          else       stage_n[0] <= 1'b0;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (clear) stage_n[k] <= 1'b1;
          else       stage_n[k] <= stage_n[k-1];
        end
        // R9
        stage_order_chk: assert property (@(posedge clk) disable iff (rst)
          !stage_n[k] |-> !stage_n[k-1]);
      end
    end
  endgenerate
endmodule

// File: rtl/ackdly_tap.sv
module ackdly_tap #(
  parameter int TAP_W = 3,
  parameter int DEPTH = 1 << TAP_W
) (
  input  logic [DEPTH-1:0] stage_n,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             tap_n
);
  assign tap_n = stage_n[tap_sel];
endmodule

// File: rtl/bus_ack_delay.sv
module bus_ack_delay #(
  parameter int                  WIN_BITS   = 3,
  parameter logic [WIN_BITS-1:0] WIN_MATCH  = 3'b100,
  parameter int                  TAP_W      = 3,
  parameter bit                  ACK_WRITES = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                as_n,
  input  logic                rw,
  input  logic [WIN_BITS-1:0] addr_top,
  input  logic [TAP_W-1:0]    tap_sel,
  output wire                 ack_n,
  output logic                ack_pull,
  output logic                mem_cs_n,
  output logic                mem_rd_n,
  output logic                mem_wr_n
);
  localparam int DEPTH = 1 << TAP_W;

  logic             run;
  logic [DEPTH-1:0] stage_n;
  logic             tap_n;

  ackdly_window #(
    .WIN_BITS  (WIN_BITS),
    .WIN_MATCH (WIN_MATCH),
    .ACK_WRITES(ACK_WRITES)
  ) u_win (
    .clk     (clk),
    .rst     (rst),
    .as_n    (as_n),
    .rw      (rw),
    .addr_top(addr_top),
    .run     (run),
    .cs_n    (mem_cs_n),
    .rd_n    (mem_rd_n),
    .wr_n    (mem_wr_n)
  );

  ackdly_chain #(.DEPTH(DEPTH)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .stage_n(stage_n)
  );

  ackdly_tap #(.TAP_W(TAP_W), .DEPTH(DEPTH)) u_tap (
    .stage_n(stage_n),
    .tap_sel(tap_sel),
    .tap_n  (tap_n)
  );

  assign ack_pull = !tap_n;
  assign ack_n    = ack_pull ? 1'b0 : 1'bz;

  // R1
  outside_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_top != WIN_MATCH) |=> !ack_pull);
  // R5
  strobe_off_release_chk: assert property (@(posedge clk) disable iff (rst)
    as_n |=> (!ack_pull && mem_cs_n));
  // R8
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (!ack_pull && mem_cs_n && mem_rd_n && mem_wr_n));
  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pull && !as_n && (addr_top == WIN_MATCH)) |=> (ack_pull || !$stable(tap_sel)));
  // R2
  ack_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_pull) |-> !mem_cs_n);
  // R6
  ack_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    ack_pull |-> (ack_n == 1'b0));
endmodule

// File: tb/tb_bus_ack_delay.sv
module tb_bus_ack_delay;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       as_n = 1'b1;
  logic       rw = 1'b1;
  logic [2:0] addr_top = 3'b000;
  logic [2:0] tap_sel = 3'd0;
  wire        ack_n;
  logic       ack_pull;
  logic       mem_cs_n, mem_rd_n, mem_wr_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pullup (ack_n);

  bus_ack_delay dut (
    .clk(clk), .rst(rst), .as_n(as_n), .rw(rw), .addr_top(addr_top),
    .tap_sel(tap_sel), .ack_n(ack_n), .ack_pull(ack_pull),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
  );

  always #5 clk = ~clk;

  function automatic bit in_win(input logic [2:0] a);
    return a == 3'b100;
  endfunction

  function automatic bit exp_ack(input logic [2:0] a, input logic [2:0] t, input int edges);
    return in_win(a) && (edges >= int'(t) + 1);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_released(input string tag);
    chk(tag, ack_pull, 1'b0);
    chk("R6", ack_n, 1'b1);
    chk(tag, mem_cs_n, 1'b1);
    chk(tag, mem_rd_n, 1'b1);
    chk(tag, mem_wr_n, 1'b1);
  endtask

  task automatic bus_cycle(input string tag, input logic [2:0] a, input logic r,
                           input logic [2:0] t, input int hold);
    @(negedge clk);
    as_n = 1'b0; addr_top = a; rw = r; tap_sel = t;
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      chk((i > int'(t) + 1) ? "R9" : tag, ack_pull, exp_ack(a, t, i));
      chk("R6", ack_n, exp_ack(a, t, i) ? 1'b0 : 1'b1);
      chk("R7", mem_cs_n, !in_win(a));
      chk("R7", mem_rd_n, !(in_win(a) && r));
      chk("R7", mem_wr_n, !(in_win(a) && !r));
    end
    as_n = 1'b1;
    @(negedge clk);
    check_released("R5");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R8: reset holds everything released even with a live in-window cycle
    as_n = 1'b0; addr_top = 3'b100; rw = 1'b1; tap_sel = 3'd0;
    repeat (3) @(negedge clk);
    check_released("R8");
    as_n = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check_released("R8");

    // R4: every tap value on reads
    for (int t = 0; t < 8; t++) bus_cycle("R4", 3'b100, 1'b1, 3'(t), t + 3);
    // R2: read, tap 3 (4 periods, covers a 450 ns part at ~130 ns)
    bus_cycle("R2", 3'b100, 1'b1, 3'd3, 6);
    // R3: writes with the same delay
    bus_cycle("R3", 3'b100, 1'b0, 3'd3, 6);
    bus_cycle("R3", 3'b100, 1'b0, 3'd7, 9);
    // R1: outside the window
    bus_cycle("R1", 3'b000, 1'b1, 3'd0, 5);
    bus_cycle("R1", 3'b101, 1'b0, 3'd0, 5);
    bus_cycle("R1", 3'b111, 1'b1, 3'd2, 5);
    bus_cycle("R1", 3'b011, 1'b1, 3'd0, 4);
    // R5: cycle ends before its acknowledge, next one restarts from stage zero
    bus_cycle("R5", 3'b100, 1'b1, 3'd5, 2);
    bus_cycle("R5", 3'b100, 1'b1, 3'd5, 8);

    // R8: reset in the middle of an acknowledged cycle
    @(negedge clk);
    as_n = 1'b0; addr_top = 3'b100; rw = 1'b1; tap_sel = 3'd0;
    repeat (3) @(negedge clk);
    chk("R8", ack_pull, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_released("R8");
    rst = 1'b0; as_n = 1'b1;
    @(negedge clk);

    // R2: random cycles
    for (int n = 0; n < 80; n++) begin
      logic [2:0] a;
      logic       r;
      logic [2:0] t;
      int         h;
      a = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'b100;
      r = 1'($urandom_range(0, 1));
      t = 3'($urandom_range(0, 7));
      h = int'($urandom_range(1, 12));
      bus_cycle("R2", a, r, t, h);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule